// File: doc/BRIEF.md
# Multi-Mode Built-In Test Register

This block is a parameterised register of `WIDTH` flip-flops meant to sit between two clouds of combinational logic. A two-bit mode code sets what it does on each clock edge. It can behave as an ordinary pipeline register. It can shift as a serial scan segment. It can clear itself. It can also run as a linear feedback register that folds its parallel inputs into a running signature.

The feedback taps come from a fixed mask parameter. The head of the chain is fed from one of two sources: the serial input while scanning, or the XOR of the tapped stages in signature mode. When the parallel inputs are held at a constant value in signature mode, the register no longer compacts anything. It then steps through a pseudorandom sequence and can drive stimulus into the logic that follows it.

Every pin is a plain level signal sampled on the rising clock edge. There is no handshake, because a register inside a datapath neither stalls nor applies back-pressure. The surrounding logic and the test sequencing are outside this block.

Top module: `bilbo_reg`

## Requirements
- R1: With `mode_sel` = 2'b11 (capture), every bit of `par_out` takes the value of the matching `par_in` bit at the next rising edge.
- R2: With `mode_sel` = 2'b00 (shift), `par_out[0]` takes `ser_in` at the next edge, and each `par_out[i]` takes the old `par_out[i-1]`. `par_in` is ignored.
- R3: With `mode_sel` = 2'b10 (signature), the next `par_out[0]` is `par_in[0]` XOR the feedback bit, and the next `par_out[i]` is `par_in[i]` XOR the old `par_out[i-1]`. The feedback bit is the XOR of the `par_out` bits selected by `TAP_MASK`. The default mask 8'hB8 selects bits 7, 5, 4 and 3. `ser_in` is ignored.
- R4: With `mode_sel` = 2'b01 (clear), `par_out` becomes all zeros at the next edge, whatever `par_in` and `ser_in` hold.
- R5: `ser_out` always equals `par_out[WIDTH-1]`.
- R6: In signature mode with `par_in` held at zero, a nonzero state never becomes zero. With the default mask it returns to its starting value after exactly 2^WIDTH-1 = 255 edges.
- R7: Driving `rst_n` low clears `par_out` at once, without waiting for a clock edge.
- R8: After a capture, `WIDTH` shift cycles present the captured word on `ser_out` most significant bit first. The register then holds the bits that entered on `ser_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all stages |
| mode_sel | input | 2 | 11 capture, 00 shift, 10 signature, 01 clear |
| par_in | input | WIDTH | Parallel data from the upstream logic |
| ser_in | input | 1 | Serial data into stage 0 while shifting |
| par_out | output | WIDTH | Register contents, driven to the downstream logic |
| ser_out | output | 1 | Last stage, continues the scan chain |

## Verification
The register holds no state beyond `par_out`, so any wrong stage value shows on `par_out` in the cycle after the faulty edge. In signature mode a wrong value keeps spreading: one bad stage or a wrong tap alters the following states and moves the sequence onto a different orbit. A feedback fault therefore shows either as a signature mismatch within one step or as a period other than 255. A fault in the head multiplexer shows within one cycle of the first shift or the first signature step.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT   = 2'b00,
    MODE_CLEAR   = 2'b01,
    MODE_SIG     = 2'b10,
    MODE_CAPTURE = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_fb.sv
module bilbo_fb #(
  parameter int unsigned        WIDTH    = 8,
  parameter logic [WIDTH-1:0]   TAP_MASK = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH-1:0] tapped;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign tapped[i] = state[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign fb = ^tapped;
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
  import bilbo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  bilbo_mode_e mode,
  input  logic        d,
  input  logic        prev,
  output logic        q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_CAPTURE: nxt = d;
      MODE_SHIFT:   nxt = prev;
      MODE_SIG:     nxt = d ^ prev;
      default:      nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  localparam int unsigned MSB = WIDTH - 1;

  bilbo_mode_e      mode;
  logic             fb;
  logic             head;
  logic [WIDTH-1:0] state;

  assign mode = bilbo_mode_e'(mode_sel);

  bilbo_fb #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state (state),
    .fb    (fb)
  );

  // head of chain: serial input while scanning, feedback otherwise
  assign head = (mode == MODE_SHIFT) ? ser_in : fb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic prev_bit;
    if (i == 0) begin : g_first
      assign prev_bit = head;
    end else begin : g_rest
      assign prev_bit = state[i-1];
    end
    bilbo_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .d     (par_in[i]),
      .prev  (prev_bit),
      .q     (state[i])
    );
  end

  assign par_out = state;
  assign ser_out = state[MSB];

  // R1: capture loads the parallel word
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |=> par_out == $past(par_in));

  // R2: shift moves toward the MSB, serial bit enters at stage 0
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |=> par_out == {$past(par_out[MSB-1:0]), $past(ser_in)});

  // R3: signature step from taps and parallel inputs
  p_sig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |=> par_out ==
      ({$past(par_out[MSB-1:0]), ^($past(par_out) & TAP_MASK)} ^ $past(par_in)));

  // R4: clear empties every stage
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> par_out == '0);

  // R6: autonomous generation never collapses to zero
  p_no_lockup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && par_in == '0 && par_out != '0) |=> par_out != '0);
endmodule

// File: tb/tb_bilbo_reg.sv
module tb_bilbo_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_sel = 2'b01;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_out;
  logic         ser_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAP_MASK(8'hB8)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .par_in(par_in), .ser_in(ser_in),
    .par_out(par_out), .ser_out(ser_out)
  );

  // {mode[1:0], par_in[7:0], ser_in, expected par_out[7:0]}
  localparam logic [18:0] VEC [12] = '{
    {2'b11, 8'hA5, 1'b0, 8'hA5},
    {2'b00, 8'h00, 1'b1, 8'h4B},
    {2'b00, 8'hFF, 1'b0, 8'h96},
    {2'b01, 8'hFF, 1'b1, 8'h00},
    {2'b11, 8'h3C, 1'b1, 8'h3C},
    {2'b10, 8'h00, 1'b1, 8'h79},
    {2'b10, 8'hFF, 1'b0, 8'h0C},
    {2'b11, 8'h81, 1'b0, 8'h81},
    {2'b10, 8'h01, 1'b1, 8'h02},
    {2'b01, 8'h5A, 1'b0, 8'h00},
    {2'b10, 8'h00, 1'b1, 8'h00},
    {2'b00, 8'hC3, 1'b1, 8'h01}
  };

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive away from the edge, clock once, settle
  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic s);
    @(negedge clk);
    mode_sel = m; par_in = d; ser_in = s;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL R6 watchdog expired actual=%h expected=done", par_out);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    logic [W-1:0] got;
    int period;

    #1;
    check(par_out == '0, "R7", par_out, '0);
    #20;
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      step(VEC[k][18:17], VEC[k][16:9], VEC[k][8]);
      case (VEC[k][18:17])
        2'b11:   tag = "R1";
        2'b00:   tag = "R2";
        2'b10:   tag = "R3";
        default: tag = "R4";
      endcase
      check(par_out == VEC[k][7:0], tag, par_out, VEC[k][7:0]);
      check(ser_out == VEC[k][7], "R5", {7'd0, ser_out}, {7'd0, VEC[k][7]});
    end

    // R8: serial unload MSB first, with new bits entering behind
    step(2'b11, 8'hD2, 1'b0);
    got = '0;
    for (int k = 0; k < W; k++) begin
      got = {got[W-2:0], ser_out};
      step(2'b00, 8'hFF, k[0]);
    end
    check(got == 8'hD2, "R8", got, 8'hD2);
    check(par_out == 8'h55, "R8", par_out, 8'h55);

    // R6: maximal period with zero inputs
    step(2'b11, 8'h01, 1'b0);
    period = 0;
    for (int k = 0; k < 300; k++) begin
      step(2'b10, 8'h00, 1'b1);
      period++;
      if (par_out == '0) begin
        check(1'b0, "R6", par_out, 8'h01);
        break;
      end
      if (par_out == 8'h01) break;
    end
    check(period == 255, "R6", period[7:0], 8'hFF);

    // R7: asynchronous clear between edges
    step(2'b11, 8'hFF, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(par_out == '0, "R7", par_out, '0);
    rst_n = 1'b1;
    #1;
    check(par_out == '0, "R7", par_out, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule